// File: doc/BRIEF.md
# Burst-Aware Memory Subordinate

This block is an AHB-Lite subordinate in front of a small word-wide internal memory. It takes reads and writes from one bus master and keeps the usual split between address phase and data phase. For an incrementing burst it keeps a small record of the burst in progress. That record holds whether a burst is open, which word the next beat should address, and one word of read-ahead data. The read-ahead word stands in for memory prefetch.

When the master pauses with BUSY, the record stays as it is. The next SEQ beat at the expected address is then answered from the read-ahead word, and no new memory read is needed. IDLE closes the record. A master-side pause (BUSY) and a subordinate-side stall are separate: the stall comes from a parameterised count of wait states that the block inserts on every beat that moves data. The `hit_ahead` output shows, during a read data phase, that the word came from the read-ahead register. This makes the retained prefetch visible at the pins.

Top module: `burstmem_sub`

## Requirements
- R1: After synchronous reset `hreadyout` is 1 and `hit_ahead` is 0.
- R2: A write (`hwrite`=1) to a word, followed later by a read of that word, returns the written data. The word is selected by `haddr[ADDR_W-1:2]`, and `haddr[1:0]` is ignored.
- R3: A BUSY cycle (`htrans`=01) gets a zero-wait OKAY and writes nothing to memory, whatever `hwrite`, `haddr` and `hwdata` carry.
- R4: An IDLE cycle (`htrans`=00) gets a zero-wait OKAY and closes the burst. A SEQ read that follows an IDLE is served from memory, and `hit_ahead` is 0.
- R5: A NONSEQ read (`htrans`=10) with an incrementing burst (`hburst` not 000) loads the word at address+4 into the read-ahead register. A following SEQ read (`htrans`=11) at that address is served from it, with `hit_ahead`=1 through its data phase. Each such hit loads the word after it.
- R6: One or more BUSY cycles between burst beats leave the burst record and the read-ahead word unchanged. The SEQ read that resumes at the held address is served from the read-ahead register with the correct data.
- R7: A SEQ read whose address differs from the expected next word gets memory data with `hit_ahead`=0, and it starts a new burst record from its own address.
- R8: A NONSEQ with `hburst`=000 (single) opens no burst. A SEQ read after it reports `hit_ahead`=0.
- R9: Every NONSEQ or SEQ data phase holds `hreadyout` low for exactly WAIT_STATES cycles (0 to 3) before it completes. BUSY and IDLE never lower it.
- R10: Address and control are taken only in a cycle with `hsel`=1 and `hready`=1. A write offered with `hsel`=0 leaves memory unchanged.
- R11: `hresp` is always 0 (OKAY).
- R12: A read accepted in the same cycle as the write to that word completes returns the new data. This holds for a read-ahead fetch too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hsel | input | 1 | Subordinate select |
| haddr | input | ADDR_W | Byte address |
| htrans | input | 2 | Transfer type: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| hwrite | input | 1 | 1 for write, 0 for read |
| hburst | input | 3 | 000 single, other values incrementing |
| hwdata | input | DATA_W | Write data, valid in the data phase |
| hready | input | 1 | Bus ready: previous transfer completes |
| hreadyout | output | 1 | Low while this block stalls a data phase |
| hresp | output | 1 | Response, always OKAY |
| hrdata | output | DATA_W | Read data |
| hit_ahead | output | 1 | Read data phase is served from the read-ahead register |

## Verification
The bench builds two copies of the block side by side, one with WAIT_STATES=0 and one with WAIT_STATES=2, and runs the same transfer script on both. The zero-wait copy issues beats back to back. This exercises the case where a SEQ hit comes one cycle after its read-ahead fetch, and the case where a read lands in the same edge as the write to its word. The two-wait copy places BUSY and IDLE cycles behind stalled data phases. It also shows that a hit stays stable across the stall and that master pauses never extend the stall.

// File: rtl/burstmem_pkg.sv
package burstmem_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  localparam logic [2:0] BURST_SINGLE = 3'b000;

  // NONSEQ and SEQ both have bit 1 set: those are the beats that move data
  function automatic logic moves_data(input logic [1:0] t);
    return t[1];
  endfunction

endpackage

// File: rtl/burstmem_ram.sv
module burstmem_ram #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 64,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re_a,
  input  logic [IDX_W-1:0]  raddr_a,
  output logic [WORD_W-1:0] rdata_a,
  input  logic              re_b,
  input  logic [IDX_W-1:0]  raddr_b,
  output logic [WORD_W-1:0] rdata_b
);

  logic [WORD_W-1:0] mem [DEPTH];

  // one write port, two registered read ports, write-first on a collision
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re_a) rdata_a <= (we && waddr == raddr_a) ? wdata : mem[raddr_a];
    if (re_b) rdata_b <= (we && waddr == raddr_b) ? wdata : mem[raddr_b];
  end

endmodule

// File: rtl/burstmem_pace.sv
module burstmem_pace #(
  parameter int WAIT_STATES = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic ready,
  output logic done
);

  logic busy;

  generate
    if (WAIT_STATES == 0) begin : g_nowait
      always_ff @(posedge clk) begin
        if (rst)        busy <= 1'b0;
        else if (start) busy <= 1'b1;
        else if (busy)  busy <= 1'b0;
      end
      assign ready = 1'b1;
    end else begin : g_wait
      localparam int CW = $clog2(WAIT_STATES + 1);
      logic [CW-1:0] cnt;
      logic          rdy;
      always_ff @(posedge clk) begin
        if (rst) begin
          busy <= 1'b0;
          rdy  <= 1'b1;
          cnt  <= '0;
        end else if (start) begin
          busy <= 1'b1;
          rdy  <= 1'b0;
          cnt  <= CW'(WAIT_STATES);
        end else if (busy && !rdy) begin
          cnt <= cnt - CW'(1);
          rdy <= (cnt == CW'(1));
        end else if (busy) begin
          busy <= 1'b0;
        end
      end
      assign ready = rdy;
    end
  endgenerate

  assign done = busy & ready;

endmodule

// File: rtl/burstmem_ctx.sv
module burstmem_ctx
  import burstmem_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  logic [1:0]        trans,
  input  logic              is_write,
  input  logic              incr,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] ahead_word,
  output logic              hit,
  output logic              fetch_next,
  output logic [WORD_W-1:0] buf_word
);

  logic              open_q;
  logic              pf_ok;
  logic              pf_load;
  logic [IDX_W-1:0]  next_idx;
  logic [WORD_W-1:0] pf_data;
  logic              match;
  logic              keep_open;
  logic              is_seq;

  always_comb begin
    is_seq     = (trans == TR_SEQ);
    match      = open_q && (idx == next_idx);
    keep_open  = (is_seq && match) || incr;
    hit        = acc && is_seq && !is_write && match && pf_ok;
    fetch_next = acc && moves_data(trans) && !is_write && keep_open;
    // the RAM port holds the fresh look-ahead word for one cycle after the fetch
    buf_word   = pf_load ? ahead_word : pf_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q   <= 1'b0;
      pf_ok    <= 1'b0;
      pf_load  <= 1'b0;
      next_idx <= '0;
      pf_data  <= '0;
    end else begin
      pf_load <= 1'b0;
      if (pf_load) pf_data <= ahead_word;
      if (acc) begin
        if (trans == TR_IDLE) begin
          open_q <= 1'b0;
          pf_ok  <= 1'b0;
        end else if (moves_data(trans)) begin
          open_q   <= keep_open;
          next_idx <= idx + 1'b1;
          pf_ok    <= fetch_next;
          pf_load  <= fetch_next;
        end
        // BUSY: record and read-ahead word left untouched
      end
    end
  end

endmodule

// File: rtl/burstmem_sub.sv
module burstmem_sub
  import burstmem_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int WAIT_STATES = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [2:0]        hburst,
  input  logic [DATA_W-1:0] hwdata,
  input  logic              hready,
  output logic              hreadyout,
  output logic              hresp,
  output logic [DATA_W-1:0] hrdata,
  output logic              hit_ahead
);

  localparam int IDX_W = ADDR_W - 2;
  localparam int DEPTH = 1 << IDX_W;

  logic              acc;
  logic              acc_move;
  logic [IDX_W-1:0]  idx;
  logic              unused_lsbs;
  logic              incr;
  logic              hit;
  logic              fetch_next;
  logic [DATA_W-1:0] buf_word;
  logic [DATA_W-1:0] rd_a;
  logic [DATA_W-1:0] rd_b;
  logic [DATA_W-1:0] hold_q;
  logic              hit_q;
  logic              dp_wr;
  logic [IDX_W-1:0]  dp_idx;
  logic              dp_done;
  logic              ram_we;

  assign acc         = hsel & hready;
  assign acc_move    = acc & moves_data(htrans);
  assign idx         = haddr[ADDR_W-1:2];
  assign unused_lsbs = ^haddr[1:0];
  assign incr        = (hburst != BURST_SINGLE);
  assign ram_we      = dp_done & dp_wr;

  burstmem_pace #(.WAIT_STATES(WAIT_STATES)) u_pace (
    .clk   (clk),
    .rst   (rst),
    .start (acc_move),
    .ready (hreadyout),
    .done  (dp_done)
  );

  burstmem_ctx #(.IDX_W(IDX_W), .WORD_W(DATA_W)) u_ctx (
    .clk        (clk),
    .rst        (rst),
    .acc        (acc),
    .trans      (htrans),
    .is_write   (hwrite),
    .incr       (incr),
    .idx        (idx),
    .ahead_word (rd_b),
    .hit        (hit),
    .fetch_next (fetch_next),
    .buf_word   (buf_word)
  );

  burstmem_ram #(.WORD_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_ram (
    .clk     (clk),
    .we      (ram_we),
    .waddr   (dp_idx),
    .wdata   (hwdata),
    .re_a    (acc_move & ~hwrite & ~hit),
    .raddr_a (idx),
    .rdata_a (rd_a),
    .re_b    (fetch_next),
    .raddr_b (idx + 1'b1),
    .rdata_b (rd_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dp_wr  <= 1'b0;
      dp_idx <= '0;
      hit_q  <= 1'b0;
      hold_q <= '0;
    end else if (acc) begin
      hit_q <= hit;
      if (hit) hold_q <= buf_word;
      if (acc_move) begin
        dp_wr  <= hwrite;
        dp_idx <= idx;
      end
    end
  end

  assign hrdata    = hit_q ? hold_q : rd_a;
  assign hit_ahead = hit_q;
  assign hresp     = 1'b0;

endmodule

// File: rtl/burstmem_chk.sv
module burstmem_chk #(
  parameter int WAIT_STATES = 0
) (
  input logic       clk,
  input logic       rst,
  input logic       hsel,
  input logic       hready,
  input logic [1:0] htrans,
  input logic       hreadyout,
  input logic       hit_ahead,
  input logic       ram_we
);

  logic [2:0] low_run;
  logic       last_idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_run   <= '0;
      last_idle <= 1'b0;
    end else begin
      low_run <= hreadyout ? 3'd0 : low_run + 3'd1;
      if (hsel && hready) last_idle <= (htrans == 2'b00);
    end
  end

  AST_PAUSE_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    (hsel && hready && htrans == 2'b01) |=> hreadyout); // R3

  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    (hsel && hready && htrans == 2'b00) |=> hreadyout); // R4

  AST_IDLE_THEN_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    (hsel && hready && htrans == 2'b11 && last_idle) |=> !hit_ahead); // R4

  AST_HIT_ONLY_SEQ: assert property (@(posedge clk) disable iff (rst)
    (hsel && hready && htrans != 2'b11) |=> !hit_ahead); // R5

  AST_STALL_STARTS: assert property (@(posedge clk) disable iff (rst)
    (WAIT_STATES > 0 && hsel && hready && htrans[1]) |=> !hreadyout); // R9

  AST_STALL_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(low_run) <= WAIT_STATES); // R9

  AST_WRITE_ON_COMPLETE: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> hreadyout); // R2

  AST_UNSELECTED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (hready && !hsel) |=> !ram_we); // R10

endmodule

bind burstmem_sub burstmem_chk #(.WAIT_STATES(WAIT_STATES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .hsel      (hsel),
  .hready    (hready),
  .htrans    (htrans),
  .hreadyout (hreadyout),
  .hit_ahead (hit_ahead),
  .ram_we    (ram_we)
);

// File: tb/burstmem_sub_test.sv
module burstmem_rig #(
  parameter int WAITS = 0
) (
  input  logic clk,
  input  logic rst,
  output logic done,
  output int   checks,
  output int   fails
);

  localparam int AW    = 8;
  localparam int DEPTH = 64;
  localparam logic [1:0] IDL = 2'b00, BSY = 2'b01, NSQ = 2'b10, SQ = 2'b11;
  localparam logic [2:0] SGL = 3'b000, INC = 3'b001;

  logic          hsel, hwrite, hready, hreadyout, hresp, hit_ahead;
  logic [1:0]    htrans;
  logic [2:0]    hburst;
  logic [AW-1:0] haddr;
  logic [31:0]   hwdata, hrdata;
  logic [31:0]   pend;
  string         tag;

  int sc_checks = 0, sc_fails = 0, mc_checks = 0, mc_fails = 0;
  assign checks = sc_checks + mc_checks;
  assign fails  = sc_fails + mc_fails;
  assign hready = hreadyout;

  burstmem_sub #(.ADDR_W(AW), .DATA_W(32), .WAIT_STATES(WAITS)) uut (
    .clk(clk), .rst(rst), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hburst(hburst), .hwdata(hwdata), .hready(hready),
    .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata), .hit_ahead(hit_ahead)
  );

  // behavioural reference
  logic [31:0] mref [DEPTH];
  bit          kref [DEPTH];
  int          dp, m_idx, wleft, ctx_next, ix;
  bit          exp_ready, exp_hit, exp_known, ctx_on, pf_ok, rdy, cont_e, on_e;
  logic [31:0] exp_data;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin mref[i] = '0; kref[i] = 1'b0; end
    dp = 0; exp_ready = 1'b1; exp_hit = 1'b0; ctx_on = 1'b0; pf_ok = 1'b0;
    ctx_next = 0; wleft = 0; exp_known = 1'b0; exp_data = '0; m_idx = 0;
  end

  always @(posedge clk) begin
    if (rst) begin
      dp = 0; exp_ready = 1'b1; exp_hit = 1'b0; ctx_on = 1'b0; pf_ok = 1'b0;
      ctx_next = 0; wleft = 0;
    end else begin
      rdy = exp_ready;
      if (dp != 0) begin
        if (rdy) begin
          if (dp == 2) begin mref[m_idx] = hwdata; kref[m_idx] = 1'b1; end
          dp = 0;
        end else begin
          wleft--;
          exp_ready = (wleft == 0);
        end
      end
      if (hsel && rdy) begin
        if (htrans == IDL) begin
          ctx_on = 1'b0; pf_ok = 1'b0; exp_hit = 1'b0;
        end else if (htrans == BSY) begin
          exp_hit = 1'b0;
        end else begin
          ix      = int'(haddr) / 4;
          cont_e  = ctx_on && ix == ctx_next && htrans == SQ;
          exp_hit = cont_e && pf_ok && !hwrite;
          on_e    = cont_e || (hburst != SGL);
          ctx_on  = on_e;
          ctx_next = (ix + 1) % DEPTH;
          pf_ok   = on_e && !hwrite;
          dp      = hwrite ? 2 : 1;
          m_idx   = ix;
          if (!hwrite) begin exp_data = mref[ix]; exp_known = kref[ix]; end
          wleft     = WAITS;
          exp_ready = (WAITS == 0);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      mc_checks++;
      if (hreadyout !== exp_ready) begin
        mc_fails++;
        $display("FAIL R9 w%0d hreadyout=%b expected %b", WAITS, hreadyout, exp_ready);
      end
      mc_checks++;
      if (hresp !== 1'b0) begin
        mc_fails++;
        $display("FAIL R11 w%0d hresp=%b expected 0", WAITS, hresp);
      end
      if (dp == 1) begin
        mc_checks++;
        if (hit_ahead !== exp_hit) begin
          mc_fails++;
          $display("FAIL %s w%0d hit_ahead=%b expected %b", tag, WAITS, hit_ahead, exp_hit);
        end
        if (exp_ready && exp_known) begin
          mc_checks++;
          if (hrdata !== exp_data) begin
            mc_fails++;
            $display("FAIL %s w%0d hrdata=%h expected %h", tag, WAITS, hrdata, exp_data);
          end
        end
      end
    end
  end

  task automatic beat(input bit sel, input logic [1:0] tr, input bit wr,
                      input logic [2:0] bu, input int addr, input logic [31:0] wd);
    @(negedge clk);
    hwdata = pend;
    hsel   = sel;
    htrans = tr;
    hwrite = wr;
    hburst = bu;
    haddr  = addr[AW-1:0];
    while (hreadyout !== 1'b1) @(negedge clk);
    pend = wd;
  endtask

  task automatic idles(input int n);
    for (int i = 0; i < n; i++) beat(1'b1, IDL, 1'b0, SGL, 0, 32'h0);
  endtask

  initial begin
    done = 1'b0; tag = "R5"; pend = '0;
    hsel = 1'b0; htrans = IDL; hwrite = 1'b0; hburst = SGL; haddr = '0; hwdata = '0;
    @(negedge clk);
    while (rst) @(negedge clk);

    sc_checks++;
    if (hreadyout !== 1'b1 || hit_ahead !== 1'b0) begin
      sc_fails++;
      $display("FAIL R1 w%0d hreadyout=%b hit_ahead=%b expected 1 0", WAITS, hreadyout, hit_ahead);
    end

    tag = "R2";  // incrementing write burst, then reads check the data
    beat(1, NSQ, 1, INC, 'h00, 32'h1111_0000);
    beat(1, SQ,  1, INC, 'h04, 32'h2222_0004);
    beat(1, SQ,  1, INC, 'h08, 32'h3333_0008);
    beat(1, SQ,  1, INC, 'h0C, 32'h4444_000C);
    idles(2);

    tag = "R5";  // read burst served from the look-ahead word
    beat(1, NSQ, 0, INC, 'h00, 0);
    beat(1, SQ,  0, INC, 'h04, 0);
    beat(1, SQ,  0, INC, 'h08, 0);
    beat(1, SQ,  0, INC, 'h0C, 0);
    idles(2);

    tag = "R6";  // BUSY pauses keep the record and the buffered word
    beat(1, NSQ, 0, INC, 'h00, 0);
    beat(1, SQ,  0, INC, 'h04, 0);
    beat(1, BSY, 1, INC, 'h08, 32'hDEAD_0001);
    beat(1, BSY, 1, INC, 'h08, 32'hDEAD_0002);
    beat(1, SQ,  0, INC, 'h08, 0);
    beat(1, SQ,  0, INC, 'h0C, 0);
    idles(2);

    tag = "R3";  // BUSY inside a write burst writes nothing
    beat(1, NSQ, 1, SGL, 'h18, 32'h5555_0018);
    beat(1, NSQ, 1, INC, 'h10, 32'h6666_0010);
    beat(1, BSY, 1, INC, 'h14, 32'hBAD0_0014);
    beat(1, SQ,  1, INC, 'h14, 32'h7777_0014);
    beat(1, BSY, 1, INC, 'h18, 32'hBAD0_0018);
    idles(2);
    beat(1, NSQ, 0, SGL, 'h10, 0);
    beat(1, NSQ, 0, SGL, 'h14, 0);
    beat(1, NSQ, 0, SGL, 'h18, 0);
    idles(2);

    tag = "R4";  // IDLE closes the burst
    beat(1, NSQ, 0, INC, 'h00, 0);
    beat(1, IDL, 0, INC, 'h04, 0);
    beat(1, SQ,  0, INC, 'h04, 0);
    idles(2);

    tag = "R7";  // SEQ off the expected address restarts the record
    beat(1, NSQ, 1, INC, 'h20, 32'hA0A0_0020);
    beat(1, SQ,  1, INC, 'h24, 32'hA1A1_0024);
    beat(1, SQ,  1, INC, 'h28, 32'hA2A2_0028);
    beat(1, SQ,  1, INC, 'h2C, 32'hA3A3_002C);
    idles(1);
    beat(1, NSQ, 0, INC, 'h20, 0);
    beat(1, SQ,  0, INC, 'h28, 0);
    beat(1, SQ,  0, INC, 'h2C, 0);
    idles(2);

    tag = "R8";  // single transfer opens no burst
    beat(1, NSQ, 0, SGL, 'h00, 0);
    beat(1, SQ,  0, SGL, 'h04, 0);
    idles(2);

    tag = "R10";  // unselected write is not taken
    beat(0, NSQ, 1, SGL, 'h00, 32'hFFFF_FFFF);
    beat(0, NSQ, 1, SGL, 'h00, 32'hEEEE_EEEE);
    beat(1, NSQ, 0, SGL, 'h00, 0);
    idles(2);

    tag = "R12";  // read meets a write to the same word in the same edge
    beat(1, NSQ, 1, SGL, 'h30, 32'hC0DE_0030);
    beat(1, NSQ, 0, SGL, 'h30, 0);
    beat(1, NSQ, 1, SGL, 'h30, 32'hC0DE_1030);
    beat(1, NSQ, 0, INC, 'h2C, 0);
    beat(1, SQ,  0, INC, 'h30, 0);
    idles(3);

    done = 1'b1;
  end

endmodule

module burstmem_sub_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic d0, d2;
  int   c0, c2, f0, f2;

  always #5 clk = ~clk;

  burstmem_rig #(.WAITS(0)) rig_w0 (.clk(clk), .rst(rst), .done(d0), .checks(c0), .fails(f0));
  burstmem_rig #(.WAITS(2)) rig_w2 (.clk(clk), .rst(rst), .done(d2), .checks(c2), .fails(f2));

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
  end

  initial begin
    int n;
    int wd_fail;
    n = 0;
    wd_fail = 0;
    @(negedge clk);
    while (!(d0 === 1'b1 && d2 === 1'b1) && n < 20000) begin
      @(posedge clk);
      n++;
    end
    if (!(d0 === 1'b1 && d2 === 1'b1)) begin
      wd_fail = 1;
      $display("FAIL watchdog expired after %0d cycles, expected completion", n);
    end
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", c0 + c2 + wd_fail, f0 + f2 + wd_fail);
    $finish;
  end

endmodule